// File: doc/BRIEF.md
# Data-Space Pointer Address Generator

This block forms the effective data-space address for each load or store of a small 8-bit core. It keeps a local copy of three 16-bit pointers (called X, Y and Z here), each an aliased pair of byte entries in the core's 32-entry register file. Writes to those register-file entries are snooped so the copy stays coherent. When an addressing operation changes a pointer, the block emits a paired low/high byte write-back so the register file receives the new value.

For each accepted operation the block registers the effective address. It classifies that address into one of three regions of one linear space: register file, I/O or SRAM. Addresses past the SRAM raise an out-of-range flag. A constant-load operation turns Z into a program-memory word address and a byte select. The SRAM array, the instruction decoder and the ALU sit outside this block.

Top module: `dsAddrGen`

## Requirements
- R1: After reset `addrValid`, `wbLoEn`, `wbHiEn`, `effAddr` and `regionSel` are all zero, and all three pointers read as 0x0000.
- R2: A register-file write (`rfWrEn`) to index 26/27 (X), 28/29 (Y) or 30/31 (Z) updates the pointer's low byte for the even index and its high byte for the odd index. The other byte is left unchanged.
- R3: Mode 0 (direct) yields `effAddr` equal to `directAddr` and produces no pointer write-back.
- R4: Mode 5 (I/O-relative) yields `effAddr` equal to `directAddr[5:0]` plus 0x20.
- R5: Mode 1 (indirect) yields `effAddr` equal to the pointer chosen by `ptrSel`, where 0 selects X, 1 selects Y and 2 selects Z.
- R6: Mode 2 (displacement) yields Y or Z plus the zero-extended 6-bit `disp`. With `ptrSel` equal to X the operation is rejected: no `addrValid` and no write-back.
- R7: Mode 3 (pre-decrement) yields the pointer minus 1 as `effAddr` and writes that same value back. 0x0000 wraps to 0xFFFF.
- R8: Mode 4 (post-increment) yields the unchanged pointer as `effAddr` and writes back the pointer plus 1. 0xFFFF wraps to 0x0000. Both write enables assert in the same cycle, with `wbLoIdx` set to the even index and `wbHiIdx` to the odd index.
- R9: `regionSel` is one-hot for data addresses. Bit 0 covers 0x000–0x01F (register file), bit 1 covers 0x020–0x05F (I/O) and bit 2 covers 0x060–0x15F (SRAM).
- R10: A data address above 0x15F raises `outOfRange` and leaves `regionSel` at zero.
- R11: Mode 6 (constant load) reads Z regardless of `ptrSel`. It gives `progWord` = Z[15:1] and `progHiByte` = Z[0], with no write-back and no region.
- R12: Results appear one clock after `opValid` and `addrValid` pulses for that single cycle. A `ptrSel` of 3 in any pointer mode, or mode 7, is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Addressing operation present this cycle |
| mode | input | 3 | Addressing mode code |
| ptrSel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| disp | input | 6 | Unsigned displacement |
| directAddr | input | 16 | Direct address, or I/O offset in bits 5:0 |
| rfWrEn | input | 1 | Register-file write strobe (snooped) |
| rfWrIdx | input | 5 | Register-file write index |
| rfWrData | input | 8 | Register-file write byte |
| addrValid | output | 1 | Effective address valid |
| effAddr | output | 16 | Effective address |
| regionSel | output | 3 | One-hot region: bit0 regs, bit1 I/O, bit2 SRAM |
| outOfRange | output | 1 | Data address beyond SRAM |
| wbLoEn | output | 1 | Pointer low-byte write-back enable |
| wbHiEn | output | 1 | Pointer high-byte write-back enable |
| wbLoIdx | output | 5 | Register index for the low byte |
| wbHiIdx | output | 5 | Register index for the high byte |
| wbValue | output | 16 | Updated pointer value |
| progWord | output | 15 | Program-memory word address |
| progHiByte | output | 1 | High byte of the program word selected |

## Verification
A corrupted pointer copy stays hidden until an operation reads it. An indirect access on the damaged pointer then shows the wrong `effAddr` one clock after issue. Each run of auto-modify operations therefore ends with an indirect read of the same pointer. A wrong step or lost write-back shows on the very next access as a repeated or skipped address. Region-decode faults show at the boundary addresses 0x1F/0x20, 0x5F/0x60 and 0x15F/0x160 in the cycle the address is presented.

// File: rtl/dsAgenPkg.sv
package dsAgenPkg;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_IND     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_PREDEC  = 3'd3,
    MODE_POSTINC = 3'd4,
    MODE_IOREL   = 3'd5,
    MODE_CONST   = 3'd6
  } agenMode_e;

  typedef struct packed {
    logic take;
    logic usePtr;
    logic addDisp;
    logic preDec;
    logic postInc;
    logic ioRel;
    logic constLd;
    logic wrBack;
  } agenStrobe_t;

endpackage

// File: rtl/dsAgenCtrl.sv
module dsAgenCtrl
  import dsAgenPkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] ptrSel,
  output agenStrobe_t      strobe
);

  logic ptrOk;
  assign ptrOk = (int'(ptrSel) < NUM_PTR);

  always_comb begin
    strobe = '0;
    case (mode)
      MODE_DIRECT: strobe.take = opValid;
      MODE_IOREL: begin
        strobe.take  = opValid;
        strobe.ioRel = 1'b1;
      end
      MODE_IND: begin
        strobe.take   = opValid && ptrOk;
        strobe.usePtr = 1'b1;
      end
      MODE_DISP: begin
        strobe.take    = opValid && ptrOk && (ptrSel != '0);
        strobe.usePtr  = 1'b1;
        strobe.addDisp = 1'b1;
      end
      MODE_PREDEC: begin
        strobe.take   = opValid && ptrOk;
        strobe.usePtr = 1'b1;
        strobe.preDec = 1'b1;
        strobe.wrBack = opValid && ptrOk;
      end
      MODE_POSTINC: begin
        strobe.take    = opValid && ptrOk;
        strobe.usePtr  = 1'b1;
        strobe.postInc = 1'b1;
        strobe.wrBack  = opValid && ptrOk;
      end
      MODE_CONST: begin
        strobe.take    = opValid;
        strobe.constLd = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  AST_CONST_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    strobe.constLd |-> !strobe.wrBack); // R11
  AST_WB_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrBack |-> strobe.take); // R12

endmodule

// File: rtl/dsAgenRegion.sv
module dsAgenRegion #(
  parameter int ADDR_W    = 16,
  parameter int RF_SIZE   = 32,
  parameter int IO_SIZE   = 64,
  parameter int SRAM_SIZE = 256
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        regionSel,
  output logic              outOfRange
);

  localparam int IO_BASE   = RF_SIZE;
  localparam int SRAM_BASE = IO_BASE + IO_SIZE;
  localparam int SPACE_END = SRAM_BASE + SRAM_SIZE;

  int unsigned addrInt;
  assign addrInt = int'(addr);

  always_comb begin
    regionSel  = '0;
    outOfRange = 1'b0;
    if (addrInt < IO_BASE)        regionSel = 3'b001;
    else if (addrInt < SRAM_BASE) regionSel = 3'b010;
    else if (addrInt < SPACE_END) regionSel = 3'b100;
    else                          outOfRange = 1'b1;
  end

endmodule

// File: rtl/dsAgenDatapath.sv
module dsAgenDatapath
  import dsAgenPkg::*;
#(
  parameter int PTR_W        = 16,
  parameter int DISP_W       = 6,
  parameter int RF_IDX_W     = 5,
  parameter int NUM_PTR      = 3,
  parameter int SEL_W        = 2,
  parameter int PTR_BASE_IDX = 26,
  parameter int RF_SIZE      = 32,
  parameter int IO_SIZE      = 64,
  parameter int SRAM_SIZE    = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  agenStrobe_t         strobe,
  input  logic [SEL_W-1:0]    ptrSel,
  input  logic [DISP_W-1:0]   disp,
  input  logic [PTR_W-1:0]    directAddr,
  input  logic                rfWrEn,
  input  logic [RF_IDX_W-1:0] rfWrIdx,
  input  logic [7:0]          rfWrData,
  output logic                addrValid,
  output logic [PTR_W-1:0]    effAddr,
  output logic [2:0]          regionSel,
  output logic                outOfRange,
  output logic                wbLoEn,
  output logic                wbHiEn,
  output logic [RF_IDX_W-1:0] wbLoIdx,
  output logic [RF_IDX_W-1:0] wbHiIdx,
  output logic [PTR_W-1:0]    wbValue,
  output logic [PTR_W-2:0]    progWord,
  output logic                progHiByte
);

  localparam int IO_REL_W = $clog2(IO_SIZE);
  localparam int Z_SEL    = NUM_PTR - 1;
  localparam int HALF_W   = PTR_W / 2;

  logic [PTR_W-1:0] ptrVal [NUM_PTR];
  logic [SEL_W-1:0] effSel;
  logic [PTR_W-1:0] basePtr;
  logic [PTR_W-1:0] addrNext;
  logic [PTR_W-1:0] nextPtr;
  logic [2:0]       regionNext;
  logic             oorNext;

  assign effSel = strobe.constLd ? SEL_W'(Z_SEL) : ptrSel;

  always_comb begin
    basePtr = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (int'(effSel) == i) basePtr = ptrVal[i];
    end
  end

  always_comb begin
    nextPtr = basePtr;
    if (strobe.preDec)       nextPtr = basePtr - PTR_W'(1);
    else if (strobe.postInc) nextPtr = basePtr + PTR_W'(1);
  end

  always_comb begin
    if (strobe.ioRel)
      addrNext = PTR_W'(RF_SIZE) + PTR_W'(directAddr[IO_REL_W-1:0]);
    else if (strobe.constLd)
      addrNext = basePtr;
    else if (strobe.addDisp)
      addrNext = basePtr + PTR_W'(disp);
    else if (strobe.preDec)
      addrNext = nextPtr;
    else if (strobe.usePtr)
      addrNext = basePtr;
    else
      addrNext = directAddr;
  end

  dsAgenRegion #(
    .ADDR_W(PTR_W), .RF_SIZE(RF_SIZE), .IO_SIZE(IO_SIZE), .SRAM_SIZE(SRAM_SIZE)
  ) uRegion (
    .addr(addrNext), .regionSel(regionNext), .outOfRange(oorNext)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : gPtr
    localparam int LO_IDX = PTR_BASE_IDX + 2 * g;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptrVal[g] <= '0;
      end else if (strobe.wrBack && int'(effSel) == g) begin
        ptrVal[g] <= nextPtr;
      end else if (rfWrEn) begin
        if (int'(rfWrIdx) == LO_IDX)     ptrVal[g][HALF_W-1:0]     <= rfWrData;
        if (int'(rfWrIdx) == LO_IDX + 1) ptrVal[g][PTR_W-1:HALF_W] <= rfWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid  <= 1'b0;
      effAddr    <= '0;
      regionSel  <= '0;
      outOfRange <= 1'b0;
      wbLoEn     <= 1'b0;
      wbHiEn     <= 1'b0;
      wbLoIdx    <= '0;
      wbHiIdx    <= '0;
      wbValue    <= '0;
      progWord   <= '0;
      progHiByte <= 1'b0;
    end else begin
      addrValid <= strobe.take;
      wbLoEn    <= strobe.wrBack;
      wbHiEn    <= strobe.wrBack;
      if (strobe.take) begin
        effAddr    <= addrNext;
        regionSel  <= strobe.constLd ? 3'b000 : regionNext;
        outOfRange <= strobe.constLd ? 1'b0 : oorNext;
        wbLoIdx    <= RF_IDX_W'(PTR_BASE_IDX + 2 * int'(effSel));
        wbHiIdx    <= RF_IDX_W'(PTR_BASE_IDX + 2 * int'(effSel) + 1);
        wbValue    <= nextPtr;
        progWord   <= basePtr[PTR_W-1:1];
        progHiByte <= basePtr[0];
      end
    end
  end

  AST_TAKE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> addrValid); // R12
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.take |=> !addrValid); // R12
  AST_REGION_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel)); // R9
  AST_OOR_NO_REGION: assert property (@(posedge clk) disable iff (!rstN)
    outOfRange |-> regionSel == 3'b000); // R10
  AST_WB_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wbLoEn |-> (wbValue == effAddr || wbValue == effAddr + PTR_W'(1))); // R7
  AST_WB_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    wbLoEn |-> (wbHiEn && addrValid)); // R8

endmodule

// File: rtl/dsAddrGen.sv
module dsAddrGen
  import dsAgenPkg::*;
#(
  parameter int PTR_W        = 16,
  parameter int DISP_W       = 6,
  parameter int RF_IDX_W     = 5,
  parameter int NUM_PTR      = 3,
  parameter int SEL_W        = 2,
  parameter int PTR_BASE_IDX = 26,
  parameter int RF_SIZE      = 32,
  parameter int IO_SIZE      = 64,
  parameter int SRAM_SIZE    = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          mode,
  input  logic [SEL_W-1:0]    ptrSel,
  input  logic [DISP_W-1:0]   disp,
  input  logic [PTR_W-1:0]    directAddr,
  input  logic                rfWrEn,
  input  logic [RF_IDX_W-1:0] rfWrIdx,
  input  logic [7:0]          rfWrData,
  output logic                addrValid,
  output logic [PTR_W-1:0]    effAddr,
  output logic [2:0]          regionSel,
  output logic                outOfRange,
  output logic                wbLoEn,
  output logic                wbHiEn,
  output logic [RF_IDX_W-1:0] wbLoIdx,
  output logic [RF_IDX_W-1:0] wbHiIdx,
  output logic [PTR_W-1:0]    wbValue,
  output logic [PTR_W-2:0]    progWord,
  output logic                progHiByte
);

  agenStrobe_t strobe;

  dsAgenCtrl #(.NUM_PTR(NUM_PTR), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .mode(mode),
    .ptrSel(ptrSel), .strobe(strobe)
  );

  dsAgenDatapath #(
    .PTR_W(PTR_W), .DISP_W(DISP_W), .RF_IDX_W(RF_IDX_W), .NUM_PTR(NUM_PTR),
    .SEL_W(SEL_W), .PTR_BASE_IDX(PTR_BASE_IDX), .RF_SIZE(RF_SIZE),
    .IO_SIZE(IO_SIZE), .SRAM_SIZE(SRAM_SIZE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ptrSel(ptrSel), .disp(disp),
    .directAddr(directAddr), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .addrValid(addrValid), .effAddr(effAddr),
    .regionSel(regionSel), .outOfRange(outOfRange), .wbLoEn(wbLoEn),
    .wbHiEn(wbHiEn), .wbLoIdx(wbLoIdx), .wbHiIdx(wbHiIdx), .wbValue(wbValue),
    .progWord(progWord), .progHiByte(progHiByte)
  );

endmodule

// File: tb/sim_dsAddrGen.sv
module sim_dsAddrGen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptrSel = '0;
  logic [5:0]  disp = '0;
  logic [15:0] directAddr = '0;
  logic        rfWrEn = 1'b0;
  logic [4:0]  rfWrIdx = '0;
  logic [7:0]  rfWrData = '0;
  logic        addrValid, outOfRange, wbLoEn, wbHiEn, progHiByte;
  logic [15:0] effAddr, wbValue;
  logic [2:0]  regionSel;
  logic [4:0]  wbLoIdx, wbHiIdx;
  logic [14:0] progWord;

  int checks = 0;
  int errors = 0;

  dsAddrGen u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .mode(mode), .ptrSel(ptrSel),
    .disp(disp), .directAddr(directAddr), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .addrValid(addrValid), .effAddr(effAddr),
    .regionSel(regionSel), .outOfRange(outOfRange), .wbLoEn(wbLoEn),
    .wbHiEn(wbHiEn), .wbLoIdx(wbLoIdx), .wbHiIdx(wbHiIdx), .wbValue(wbValue),
    .progWord(progWord), .progHiByte(progHiByte)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expRegion(input logic [15:0] a);
    if (a <= 16'h001F) return 3'b001;
    if (a <= 16'h005F) return 3'b010;
    if (a <= 16'h015F) return 3'b100;
    return 3'b000;
  endfunction

  task automatic rfWrite(input logic [4:0] idx, input logic [7:0] data);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrIdx = idx; rfWrData = data;
    @(negedge clk);
    rfWrEn = 1'b0;
  endtask

  task automatic setPtr(input int sel, input logic [15:0] val);
    rfWrite(5'(26 + 2 * sel), val[7:0]);
    rfWrite(5'(27 + 2 * sel), val[15:8]);
  endtask

  // issue one op; outputs are registered at the next posedge and sampled at the following negedge
  task automatic issue(input logic [2:0] m, input logic [1:0] s, input logic [5:0] d,
                       input logic [15:0] da);
    @(negedge clk);
    opValid = 1'b1; mode = m; ptrSel = s; disp = d; directAddr = da;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic chkAddr(input string req, input logic [15:0] exp);
    chk({req, " valid"}, 32'(addrValid), 32'd1);
    chk({req, " addr"}, 32'(effAddr), 32'(exp));
    chk({req, " region"}, 32'(regionSel), 32'(expRegion(exp)));
    chk({req, " oor"}, 32'(outOfRange), 32'(exp > 16'h015F));
  endtask

  task automatic readPtr(input string req, input int sel, input logic [15:0] exp);
    issue(3'd1, 2'(sel), 6'd0, 16'h0);
    chkAddr(req, exp);
  endtask

  task automatic testReset();
    chk("R1 valid", 32'(addrValid), 0);
    chk("R1 wb", 32'({wbLoEn, wbHiEn}), 0);
    chk("R1 addr", 32'(effAddr), 0);
    chk("R1 region", 32'(regionSel), 0);
    readPtr("R1 X", 0, 16'h0000);
    readPtr("R1 Z", 2, 16'h0000);
  endtask

  task automatic testRfAlias();
    setPtr(0, 16'h0123);
    readPtr("R5 X", 0, 16'h0123);
    setPtr(1, 16'h0100);
    rfWrite(5'd28, 8'h3C);
    readPtr("R2 Y low only", 1, 16'h013C);
    rfWrite(5'd31, 8'h0A);
    readPtr("R2 Z high only", 2, 16'h0A00);
  endtask

  task automatic testDirect();
    issue(3'd0, 2'd0, 6'd0, 16'h001F);
    chkAddr("R3 regs edge", 16'h001F);
    chk("R3 no wb", 32'(wbLoEn), 0);
    issue(3'd0, 2'd0, 6'd0, 16'h0020);
    chkAddr("R9 io low edge", 16'h0020);
    issue(3'd0, 2'd0, 6'd0, 16'h0060);
    chkAddr("R9 sram low edge", 16'h0060);
    issue(3'd0, 2'd0, 6'd0, 16'h015F);
    chkAddr("R9 sram top", 16'h015F);
    issue(3'd0, 2'd0, 6'd0, 16'h0160);
    chkAddr("R10 oor", 16'h0160);
    chk("R10 region zero", 32'(regionSel), 0);
  endtask

  task automatic testIo();
    issue(3'd5, 2'd0, 6'd0, 16'hFF3F);
    chkAddr("R4 io top", 16'h005F);
    issue(3'd5, 2'd0, 6'd0, 16'h0000);
    chkAddr("R4 io zero", 16'h0020);
  endtask

  task automatic testDisp();
    setPtr(1, 16'h0100);
    issue(3'd2, 2'd1, 6'd63, 16'h0);
    chkAddr("R6 Y+63", 16'h013F);
    setPtr(2, 16'h0150);
    issue(3'd2, 2'd2, 6'd16, 16'h0);
    chkAddr("R6 Z+16", 16'h0160);
    issue(3'd2, 2'd0, 6'd4, 16'h0);
    chk("R6 X rejected", 32'(addrValid), 0);
    chk("R6 X no wb", 32'(wbLoEn), 0);
  endtask

  task automatic testPreDec();
    setPtr(2, 16'h0061);
    issue(3'd3, 2'd2, 6'd0, 16'h0);
    chkAddr("R7 predec", 16'h0060);
    chk("R7 wb val", 32'(wbValue), 32'h0060);
    chk("R8 wb both", 32'({wbLoEn, wbHiEn}), 32'h3);
    chk("R8 wb idx", 32'({wbLoIdx, wbHiIdx}), 32'({5'd30, 5'd31}));
    readPtr("R7 Z kept", 2, 16'h0060);
    setPtr(1, 16'h0000);
    issue(3'd3, 2'd1, 6'd0, 16'h0);
    chkAddr("R7 wrap", 16'hFFFF);
    chk("R7 wrap wb", 32'(wbValue), 32'hFFFF);
  endtask

  task automatic testPostInc();
    setPtr(0, 16'h005F);
    issue(3'd4, 2'd0, 6'd0, 16'h0);
    chkAddr("R8 postinc", 16'h005F);
    chk("R8 wb val", 32'(wbValue), 32'h0060);
    chk("R8 wb idx", 32'({wbLoIdx, wbHiIdx}), 32'({5'd26, 5'd27}));
    issue(3'd4, 2'd0, 6'd0, 16'h0);
    chkAddr("R8 second", 16'h0060);
    setPtr(2, 16'hFFFF);
    issue(3'd4, 2'd2, 6'd0, 16'h0);
    chkAddr("R8 wrap addr", 16'hFFFF);
    chk("R8 wrap wb", 32'(wbValue), 32'h0000);
    readPtr("R8 wrap kept", 2, 16'h0000);
  endtask

  task automatic testConst();
    setPtr(2, 16'h0ABD);
    issue(3'd6, 2'd0, 6'd0, 16'h0);
    chk("R11 valid", 32'(addrValid), 1);
    chk("R11 word", 32'(progWord), 32'h055E);
    chk("R11 hi", 32'(progHiByte), 1);
    chk("R11 no wb", 32'(wbLoEn), 0);
    chk("R11 no region", 32'({regionSel, outOfRange}), 0);
    setPtr(2, 16'h0ABC);
    issue(3'd6, 2'd1, 6'd0, 16'h0);
    chk("R11 lo byte", 32'(progHiByte), 0);
  endtask

  task automatic testReject();
    setPtr(0, 16'h0040);
    issue(3'd4, 2'd3, 6'd0, 16'h0);
    chk("R12 sel3 rejected", 32'(addrValid), 0);
    chk("R12 sel3 no wb", 32'(wbLoEn), 0);
    issue(3'd7, 2'd0, 6'd0, 16'h0);
    chk("R12 mode7 rejected", 32'(addrValid), 0);
    readPtr("R12 X untouched", 0, 16'h0040);
    @(negedge clk);
    chk("R12 single pulse", 32'(addrValid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRfAlias();
    testDirect();
    testIo();
    testDisp();
    testPreDec();
    testPostInc();
    testConst();
    testReject();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule